// File: doc/BRIEF.md
# Channel Current Balance Unit

This block equalises the current carried by the phases of a multi-phase buck converter. In every switching cycle each active phase delivers one unsigned current sample, captured while that phase is held off. Once every active phase has reported, the unit forms the mean of those samples and subtracts the mean from each sample to get a signed imbalance. Each imbalance passes through a first-order low-pass filter. The filtered value is then subtracted from a shared compare level to give that phase's own compare level.

A phase that runs hotter than the mean gets a lower compare level and so a shorter on-time. This drives its imbalance back toward zero. Two, three or four phases can be active. Samples from phases that are switched out affect neither the sum nor the divisor.

Top module: `current_balance`

## Requirements
- R1: A channel's sample register loads `smp_data` when that channel's `smp_vld` bit is high at a rising clock edge and the channel is active. If a channel delivers twice before an update, the later value is used.
- R2: `act_sel` selects the active set. 2'b10 selects channels 0 and 1. 2'b11 selects channels 0 to 2. 2'b00 and 2'b01 select all four channels.
- R3: An update happens on the rising edge after every active channel has delivered at least one sample since the previous update. Outputs that depend on the filters change only at that edge. A partial set of deliveries leaves every output unchanged.
- R4: The mean is the sum of the active channels' samples divided by the active count, rounded down. It is exact for counts of two, three and four.
- R5: Each active channel's imbalance is its sample minus the mean, held as a signed value one bit wider than a sample.
- R6: On each update, each active channel's filter state f moves by floor((e - f) / 2^FSH), where e is that channel's imbalance. FSH defaults to 2, and FSH = 0 makes f equal to e.
- R7: Each channel output is `comp_in` minus its filter state, clamped to the range 0 to RAMP_MAX (default 4095). The output follows `comp_in` with no clock delay.
- R8: Inactive channels are ignored: their strobes do not count toward an update, their data does not enter the sum, and their filter state is held at zero, so their output equals `comp_in`.
- R9: While `rst_n` is low, all filter states and pending-delivery flags clear. After reset every output equals `comp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_sel | input | 2 | Active channel set select (see R2) |
| smp_vld | input | NCH | Per-channel sample strobe |
| smp_data | input | NCH*SW | Per-channel unsigned samples, channel i at bits [i*SW +: SW] |
| comp_in | input | CW | Shared compare level |
| comp_adj | output | NCH*CW | Per-channel adjusted compare levels, channel i at bits [i*CW +: CW] |

## Verification
A strobe registers its sample on the first rising edge. The filter update falls on the second rising edge, so the filter-driven outputs are due one full cycle after the edge that captured the final delivery. The bench drives strobes on a falling edge, drops them after the first rising edge, and compares the outputs on the falling edge that follows the second rising edge. This is the same point at which a partial delivery must show no change. A change of `comp_in` alone reaches the outputs with no clock, so those checks compare after a short settling delay within the same cycle.

// File: rtl/cb_pkg.sv
package cb_pkg;

   localparam int unsigned CB_MAX_CH = 4;

   function automatic logic [2:0] cb_count(input logic [1:0] sel);
      case (sel)
         2'b10:   return 3'd2;
         2'b11:   return 3'd3;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [CB_MAX_CH-1:0] cb_mask(input logic [1:0] sel);
      case (sel)
         2'b10:   return 4'b0011;
         2'b11:   return 4'b0111;
         default: return 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/cb_capture.sv
module cb_capture #(
   parameter int NCH = 4,
   parameter int SW  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    vld,
   input  logic [NCH*SW-1:0] din,
   input  logic [NCH-1:0]    mask,
   output logic [NCH*SW-1:0] smp,
   output logic              upd
);

   logic [NCH-1:0] got;
   logic [NCH-1:0] take;

   assign take = vld & mask;
   assign upd  = &(got | ~mask);

   always_ff @(posedge clk) begin
      if (!rst_n)   got <= '0;
      else if (upd) got <= take;
      else          got <= got | take;
   end

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic [SW-1:0] smp_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       smp_q <= '0;
            else if (take[i]) smp_q <= din[i*SW +: SW];
         end
         assign smp[i*SW +: SW] = smp_q;
      end
   endgenerate

   // R3: a delivery flag stays set until an update consumes it
   assert_pending_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ((got & $past(got)) == $past(got)))
      else $error("pending flag lost without update");

   // R8: inactive channels never raise a pending flag
   assert_inactive_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((got & ~$past(mask)) == '0))
      else $error("inactive channel flagged");

endmodule

// File: rtl/cb_average.sv
module cb_average #(
   parameter int NCH = 4,
   parameter int SW  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*SW-1:0] smp,
   input  logic [NCH-1:0]    mask,
   input  logic [2:0]        cnt,
   output logic [SW-1:0]     avg
);

   localparam int SUMW = SW + $clog2(NCH);
   localparam int RS   = SUMW + 1;
   localparam int PW   = SUMW + RS;
   localparam logic [RS-1:0] RECIP = RS'(((1 << RS) + 2) / 3);

   logic [SUMW-1:0] sum;
   logic [SUMW-1:0] q;
   logic [PW-1:0]   prod;

   always_comb begin
      sum = '0;
      for (int i = 0; i < NCH; i++)
         if (mask[i]) sum = sum + SUMW'(smp[i*SW +: SW]);
   end

   assign prod = PW'(sum) * PW'(RECIP);

   always_comb begin
      case (cnt)
         3'd2:    q = sum >> 1;
         3'd3:    q = SUMW'(prod >> RS);
         default: q = sum >> 2;
      endcase
   end

   assign avg = SW'(q);

   // R4: quotient is the floor of sum over count
   assert_exact_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((SUMW+1)'(avg) * (SUMW+1)'(cnt) <= (SUMW+1)'(sum)) &&
      ((SUMW+1)'(sum) - (SUMW+1)'(avg) * (SUMW+1)'(cnt) < (SUMW+1)'(cnt)))
      else $error("mean is not floor(sum/count)");

endmodule

// File: rtl/cb_filter.sv
module cb_filter #(
   parameter int SW       = 10,
   parameter int CW       = 12,
   parameter int FSH      = 2,
   parameter int RAMP_MAX = 4095
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          active,
   input  logic [SW-1:0] smp,
   input  logic [SW-1:0] avg,
   input  logic [CW-1:0] comp_in,
   output logic [CW-1:0] comp_out
);

   localparam int EW = SW + 1;
   localparam int DW = SW + 2;
   localparam int AW = CW + 2;

   logic signed [EW-1:0] err;
   logic signed [EW-1:0] f_q;
   logic signed [AW-1:0] adj;

   assign err = $signed({1'b0, smp}) - $signed({1'b0, avg});

   generate
      if (FSH == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n)       f_q <= '0;
            else if (!active) f_q <= '0;
            else if (upd)     f_q <= err;
         end
      end else begin : g_iir
         logic signed [DW-1:0] diff;
         logic signed [DW-1:0] step;
         assign diff = $signed({err[EW-1], err}) - $signed({f_q[EW-1], f_q});
         assign step = diff >>> FSH;
         always_ff @(posedge clk) begin
            if (!rst_n)       f_q <= '0;
            else if (!active) f_q <= '0;
            else if (upd)     f_q <= f_q + EW'(step);
         end
      end
   endgenerate

   assign adj = $signed({2'b00, comp_in}) - $signed({{(AW-EW){f_q[EW-1]}}, f_q});

   always_comb begin
      if (adj < 0)                               comp_out = '0;
      else if (adj > $signed(AW'(RAMP_MAX)))     comp_out = CW'(RAMP_MAX);
      else                                       comp_out = adj[CW-1:0];
   end

   // R7: output never exceeds the ramp ceiling
   assert_ramp_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
      comp_out <= CW'(RAMP_MAX))
      else $error("adjusted level above ramp maximum");

   // R3: no filter movement outside an update
   assert_state_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && active) |=> $stable(f_q))
      else $error("filter moved without update");

endmodule

// File: rtl/current_balance.sv
module current_balance #(
   parameter int NCH      = 4,
   parameter int SW       = 10,
   parameter int CW       = 12,
   parameter int FSH      = 2,
   parameter int RAMP_MAX = 4095
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        act_sel,
   input  logic [NCH-1:0]    smp_vld,
   input  logic [NCH*SW-1:0] smp_data,
   input  logic [CW-1:0]     comp_in,
   output logic [NCH*CW-1:0] comp_adj
);

   import cb_pkg::*;

   generate
      if (NCH != CB_MAX_CH) begin : g_bad_nch
         $error("NCH must equal 4");
      end
      if (CW < SW) begin : g_bad_cw
         $error("CW must be at least SW");
      end
      if (RAMP_MAX >= (1 << CW) || RAMP_MAX < 1) begin : g_bad_ramp
         $error("RAMP_MAX out of range for CW");
      end
      if (FSH < 0 || FSH > SW) begin : g_bad_fsh
         $error("FSH out of range");
      end
   endgenerate

   logic [NCH-1:0]    mask;
   logic [2:0]        cnt;
   logic [NCH*SW-1:0] smp;
   logic              upd;
   logic [SW-1:0]     avg;

   assign mask = NCH'(cb_mask(act_sel));
   assign cnt  = cb_count(act_sel);

   cb_capture #(.NCH(NCH), .SW(SW)) u_capture (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .din(smp_data),
      .mask(mask), .smp(smp), .upd(upd)
   );

   cb_average #(.NCH(NCH), .SW(SW)) u_average (
      .clk(clk), .rst_n(rst_n), .smp(smp), .mask(mask), .cnt(cnt), .avg(avg)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chan
         cb_filter #(.SW(SW), .CW(CW), .FSH(FSH), .RAMP_MAX(RAMP_MAX)) u_filter (
            .clk(clk), .rst_n(rst_n), .upd(upd), .active(mask[i]),
            .smp(smp[i*SW +: SW]), .avg(avg), .comp_in(comp_in),
            .comp_out(comp_adj[i*CW +: CW])
         );
      end
   endgenerate

endmodule

// File: tb/test_current_balance.sv
`timescale 1ns/1ps
module test_current_balance;

   typedef struct packed {
      logic [1:0]  sel;
      logic [9:0]  a, b, c, d;
      logic [11:0] cmp;
   } vec_t;

   localparam vec_t VEC [0:7] = '{
      '{2'b00, 10'd400,  10'd400, 10'd400,  10'd400, 12'd2000},
      '{2'b00, 10'd500,  10'd300, 10'd400,  10'd400, 12'd2000},
      '{2'b00, 10'd600,  10'd200, 10'd450,  10'd350, 12'd1800},
      '{2'b11, 10'd300,  10'd301, 10'd302,  10'd999, 12'd1500},
      '{2'b11, 10'd100,  10'd200, 10'd401,  10'd0,   12'd1500},
      '{2'b10, 10'd700,  10'd100, 10'd5,    10'd5,   12'd1000},
      '{2'b10, 10'd1023, 10'd0,   10'd0,    10'd0,   12'd1000},
      '{2'b01, 10'd1023, 10'd0,   10'd1023, 10'd0,   12'd1000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  act_sel = 2'b00;
   logic [3:0]  smp_vld = '0;
   logic [39:0] smp_data = '0;
   logic [11:0] comp_in = 12'd2000;
   logic [47:0] comp_adj;

   int vectors = 0;
   int miscompares = 0;
   int fm [4];
   int st [4];
   logic [3:0] pend;

   always #4 clk = ~clk;

   current_balance i_current_balance (
      .clk(clk), .rst_n(rst_n), .act_sel(act_sel), .smp_vld(smp_vld),
      .smp_data(smp_data), .comp_in(comp_in), .comp_adj(comp_adj)
   );

   function automatic logic [3:0] m_mask(input logic [1:0] sel);
      return (sel == 2'b10) ? 4'b0011 : (sel == 2'b11) ? 4'b0111 : 4'b1111;
   endfunction

   function automatic int m_sat(input int v);
      return (v < 0) ? 0 : (v > 4095) ? 4095 : v;
   endfunction

   task automatic check(input int ch, input int exp, input string req);
      int act;
      act = int'(comp_adj[ch*12 +: 12]);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s ch%0d: actual %0d expected %0d", req, ch, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < 4; i++) check(i, m_sat(int'(comp_in) - fm[i]), req);
   endtask

   // Model of one delivery round: capture, update when the active set is complete.
   task automatic drive(input logic [1:0] sel, input int s [4],
                        input logic [3:0] vm, input logic [11:0] cmp);
      logic [3:0] m;
      int n, sum, avg, e, d;
      @(negedge clk);
      act_sel = sel;
      comp_in = cmp;
      for (int i = 0; i < 4; i++) smp_data[i*10 +: 10] = 10'(s[i]);
      smp_vld = vm;
      m = m_mask(sel);
      n = (sel == 2'b10) ? 2 : (sel == 2'b11) ? 3 : 4;
      for (int i = 0; i < 4; i++) begin
         if (vm[i] && m[i]) begin st[i] = s[i]; pend[i] = 1'b1; end
         if (!m[i]) fm[i] = 0;
      end
      if ((pend & m) == m) begin
         sum = 0;
         for (int i = 0; i < 4; i++) if (m[i]) sum += st[i];
         avg = sum / n;
         for (int i = 0; i < 4; i++)
            if (m[i]) begin
               e = st[i] - avg;
               d = e - fm[i];
               fm[i] = fm[i] + (d >>> 2);
            end
         pend = '0;
      end
      @(posedge clk);
      @(negedge clk);
      smp_vld = '0;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int s [4];
      for (int i = 0; i < 4; i++) begin fm[i] = 0; st[i] = 0; end
      pend = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R9 reset state");

      // Table walk: full deliveries under various active sets (R1 R2 R4 R5 R6 R7 R8)
      for (int k = 0; k < 8; k++) begin
         s = '{int'(VEC[k].a), int'(VEC[k].b), int'(VEC[k].c), int'(VEC[k].d)};
         drive(VEC[k].sel, s, 4'hF, VEC[k].cmp);
         check_all("R4 R5 R6 R2 vector");
      end

      // R3: partial delivery changes nothing, completion updates
      s = '{800, 100, 300, 200};
      drive(2'b00, s, 4'b0111, 12'd2000);
      check_all("R3 partial");
      drive(2'b00, s, 4'b1000, 12'd2000);
      check_all("R3 completion");

      // R1: repeated delivery, latest value wins
      s = '{100, 100, 100, 100};
      drive(2'b00, s, 4'b0001, 12'd2000);
      s = '{900, 100, 100, 100};
      drive(2'b00, s, 4'b1111, 12'd2000);
      check_all("R1 latest sample");

      // R8: inactive strobe alone does not trigger, and its data is excluded
      s = '{0, 0, 0, 1000};
      drive(2'b11, s, 4'b1000, 12'd1700);
      check_all("R8 inactive strobe");
      s = '{200, 500, 350, 1023};
      drive(2'b11, s, 4'b1111, 12'd1700);
      check_all("R8 exclusion");

      // R7: saturation at both ends, and combinational follow of comp_in
      s = '{1023, 0, 600, 600};
      for (int r = 0; r < 8; r++) drive(2'b10, s, 4'b0011, 12'd100);
      check(0, 0, "R7 floor clamp");
      check_all("R7 low");
      comp_in = 12'd4090;
      #1;
      check(1, 4095, "R7 ceiling clamp");
      check(2, 4090, "R8 inactive output");
      check_all("R7 comb follow");

      // R9: reset clears filter state
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      comp_in = 12'd1234;
      for (int i = 0; i < 4; i++) fm[i] = 0;
      pend = '0;
      @(negedge clk);
      check_all("R9 reset clears");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule